// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Filter with Line Buffers

The block turns a raster stream of pixels into a stream of 3x3 window results. Every accepted pixel becomes the bottom-right corner of a fresh window. The two rows above it come from two on-chip line buffers, each one image row wide. The nine window values drive a combinational filter, which returns either the sum or the maximum of the nine. A parameter picks the filter at build time.

Each window row is a three-entry shift register. The upper two shift registers are refilled from the line buffers. On every accepted pixel, each buffer is read once at the incoming column. Each buffer is also written once, two columns behind, with the value that moves into the left slot of the row below it. Only one read port and one write port per buffer are therefore needed.

The centre of the window trails the incoming pixel by one row and one column. Results come out in raster order of centre positions, starting at centre row 1, column 0. A centre in the first or last column yields zero. A start-of-frame flag on a pixel restarts the row and column count. The result that closes each centre row carries an end-of-line flag.

Top module: `wstream_win3`

## Requirements
- R1: While reset is held, and in the first cycle after it, `resValid` is 0 and `pixReady` is 1.
- R2: In sum mode, the result for centre (y, x) with 1 <= x <= W-2 is the sum of the nine pixels in rows y-1..y+1 and columns x-1..x+1.
- R3: The result for a centre in column 0 or column W-1 is zero.
- R4: Counting from the `pixSof` pixel as index 0, the pixel with index 2W+1 produces the first result, for centre (1, 0). `resValid` rises in the cycle after that pixel is accepted. Each later accepted pixel produces exactly one result, in raster order of centres. Pixels of image rows 0 and 1, and the pixel in column 0 of row 2, produce no result.
- R5: `resEol` is 1 on a result exactly when its centre lies in column W-1.
- R6: While `resValid` is 1 and `resReady` is 0, `pixReady` is 0, and `resData` and `resEol` hold their values.
- R7: A cycle with `pixValid` low consumes nothing. It does not advance the window, and it does not produce a result. `pixData` in such a cycle has no effect on any later result.
- R8: An accepted pixel with `pixSof` = 1 becomes position (0, 0) of a new frame, even in the middle of a row. It produces no result. Results after it depend only on the new frame's pixels.
- R9: In max mode, the result for an interior centre is the largest of the nine window pixels. Border centres still give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Input pixel present |
| pixReady | output | 1 | Block can take a pixel this cycle |
| pixData | input | PIX_W | Pixel value |
| pixSof | input | 1 | Pixel is the first of a frame |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Consumer takes the result this cycle |
| resData | output | PIX_W+4 | Filtered window value |
| resEol | output | 1 | Result is the last of its centre row |

## Verification
Two functions can land in the same cycle: a new pixel is accepted while the consumer takes the previous result. When they coincide, the window shifts and `resValid` stays high with no gap and no repeat. The bench provokes this by stalling the output on a fixed period while it inserts input gaps at a different period, so the two line up on many cycles. A second coincidence comes when a start-of-frame pixel arrives while a result is still pending. The bench judges every delivered result against a queue it builds itself, from the frame images it drives and the centre positions given in the requirements. A dropped, duplicated or misplaced result therefore shows up as a value or flag mismatch, or as a count that does not match.

// File: rtl/wstream_pkg.sv
package wstream_pkg;

  typedef enum logic {
    FILT_SUM = 1'b0,
    FILT_MAX = 1'b1
  } filtKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;     // one pixel accepted this cycle: shift window, write buffers
    logic maskOut;  // current result is a border position
  } ctrlStrobe_t;

endpackage

// File: rtl/wstream_linebuf.sv
// One row of storage: one read port and one write port.
module wstream_linebuf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/wstream_ctrl.sv
// Position counters, handshake and result framing.
module wstream_ctrl
  import wstream_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             resReady,
  output logic             pixReady,
  output logic             resValid,
  output logic             resEol,
  output ctrlStrobe_t      stb,
  output logic [COL_W-1:0] rdCol,
  output logic [COL_W-1:0] wrCol
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [COL_W-1:0] WB_WRAP  = COL_W'(IMG_W - 2);
  localparam logic [1:0]       ROW_SAT  = 2'd3;  // "past row 2"

  logic [COL_W-1:0] col, effCol;
  logic [1:0]       row, effRow;
  logic             step, emitNow;
  logic             validQ, borderQ, eolQ;

  always_comb begin
    effCol   = pixSof ? '0 : col;
    effRow   = pixSof ? 2'd0 : row;
    pixReady = !validQ || resReady;
    step     = pixValid && pixReady;
    emitNow  = (effRow == ROW_SAT) || ((effRow == 2'd2) && (effCol != '0));
    rdCol    = effCol;
    wrCol    = (effCol >= COL_W'(2)) ? effCol - COL_W'(2) : effCol + WB_WRAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      row     <= '0;
      validQ  <= 1'b0;
      borderQ <= 1'b0;
      eolQ    <= 1'b0;
    end else if (step) begin
      if (effCol == LAST_COL) begin
        col <= '0;
        row <= (effRow == ROW_SAT) ? ROW_SAT : effRow + 2'd1;
      end else begin
        col <= effCol + COL_W'(1);
        row <= effRow;
      end
      validQ  <= emitNow;
      borderQ <= (effCol < COL_W'(2));
      eolQ    <= (effCol == '0);
    end else if (resReady) begin
      validQ <= 1'b0;
    end
  end

  assign resValid    = validQ;
  assign resEol      = eolQ;
  assign stb.step    = step;
  assign stb.maskOut = borderQ;

endmodule

// File: rtl/wstream_dp.sv
// Window shift registers, the two line buffers and the filter.
module wstream_dp
  import wstream_pkg::*;
#(
  parameter int        PIX_W = 8,
  parameter int        IMG_W = 8,
  parameter int        COL_W = 3,
  parameter filtKind_e FILT  = FILT_SUM
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      stb,
  input  logic [PIX_W-1:0] pixData,
  input  logic [COL_W-1:0] rdCol,
  input  logic [COL_W-1:0] wrCol,
  output logic [PIX_W+3:0] resData
);

  localparam int OUT_W = PIX_W + 4;
  localparam int TAPS  = 3;

  // win[row][tap]: row 0 top, 2 bottom; tap 0 left, 2 right
  logic [TAPS-1:0][TAPS-1:0][PIX_W-1:0] win;
  logic [TAPS-1:0][PIX_W-1:0]           rowIn;
  logic [OUT_W-1:0]                     filtVal;

  // buffer k feeds window row k; written from the middle tap of row k+1
  for (genvar k = 0; k < TAPS - 1; k++) begin : gBuf
    wstream_linebuf #(
      .DEPTH (IMG_W),
      .DATA_W(PIX_W),
      .ADDR_W(COL_W)
    ) uBuf (
      .clk   (clk),
      .wrEn  (stb.step),
      .wrAddr(wrCol),
      .wrData(win[k+1][1]),
      .rdAddr(rdCol),
      .rdData(rowIn[k])
    );
  end

  assign rowIn[TAPS-1] = pixData;

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else if (stb.step) begin
      for (int r = 0; r < TAPS; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
        win[r][2] <= rowIn[r];
      end
    end
  end

  if (FILT == FILT_SUM) begin : gSum
    always_comb begin
      filtVal = '0;
      for (int r = 0; r < TAPS; r++)
        for (int t = 0; t < TAPS; t++)
          filtVal = filtVal + OUT_W'(win[r][t]);
    end
  end else begin : gMax
    always_comb begin
      filtVal = '0;
      for (int r = 0; r < TAPS; r++)
        for (int t = 0; t < TAPS; t++)
          if (OUT_W'(win[r][t]) > filtVal) filtVal = OUT_W'(win[r][t]);
    end
  end

  assign resData = stb.maskOut ? '0 : filtVal;

endmodule

// File: rtl/wstream_win3.sv
module wstream_win3
  import wstream_pkg::*;
#(
  parameter int        PIX_W = 8,
  parameter int        IMG_W = 8,
  parameter filtKind_e FILT  = FILT_SUM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [PIX_W-1:0] pixData,
  input  logic             pixSof,
  output logic             resValid,
  input  logic             resReady,
  output logic [PIX_W+3:0] resData,
  output logic             resEol
);

  localparam int COL_W = (IMG_W > 2) ? $clog2(IMG_W) : 2;

  ctrlStrobe_t      stb;
  logic [COL_W-1:0] rdCol, wrCol;

  wstream_ctrl #(
    .IMG_W(IMG_W),
    .COL_W(COL_W)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .pixValid(pixValid),
    .pixSof  (pixSof),
    .resReady(resReady),
    .pixReady(pixReady),
    .resValid(resValid),
    .resEol  (resEol),
    .stb     (stb),
    .rdCol   (rdCol),
    .wrCol   (wrCol)
  );

  wstream_dp #(
    .PIX_W(PIX_W),
    .IMG_W(IMG_W),
    .COL_W(COL_W),
    .FILT (FILT)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .pixData(pixData),
    .rdCol  (rdCol),
    .wrCol  (wrCol),
    .resData(resData)
  );

endmodule

// File: rtl/wstream_win3_chk.sv
module wstream_win3_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pixValid,
  input logic             pixReady,
  input logic [PIX_W-1:0] pixData,
  input logic             pixSof,
  input logic             resValid,
  input logic             resReady,
  input logic [PIX_W+3:0] resData,
  input logic             resEol
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!resValid && pixReady)); // R1

  AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resValid && resEol) |-> (resData == '0)); // R3

  AST_STALL_IN: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |-> !pixReady); // R6

  AST_HOLD_RES: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> (resValid && $stable(resData) && $stable(resEol))); // R6

  AST_NO_PIX_NO_RES: assert property (@(posedge clk) disable iff (rst)
    (!pixValid && resValid && resReady) |=> !resValid); // R7

  AST_SOF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (pixValid && pixReady && pixSof) |=> !resValid); // R8

endmodule

bind wstream_win3 wstream_win3_chk #(.PIX_W(PIX_W)) uChk (.*);

// File: tb/sim_wstream_win3.sv
`timescale 1ns/1ps
module sim_wstream_win3;
  import wstream_pkg::*;

  localparam int PW = 8;
  localparam int W  = 8;
  localparam int OW = PW + 4;
  localparam int NSCN = 6;
  // rows, tail pixels, gap period, stall period, seed
  localparam int SCN [NSCN][5] = '{
    '{4, 0, 0, 0, 1},
    '{5, 0, 3, 0, 2},
    '{4, 0, 0, 2, 3},
    '{6, 3, 4, 3, 4},
    '{3, 5, 0, 0, 5},
    '{5, 0, 2, 5, 6}
  };

  logic clk = 0;
  logic rst = 1;
  logic pixValid = 0, pixSof = 0, resReady = 0;
  logic [PW-1:0] pixData = '0;
  logic pixReady0, pixReady1, resValid0, resValid1, resEol0, resEol1;
  logic [OW-1:0] resData0, resData1;

  int checks = 0, errors = 0, cyc = 0;
  int stallCur = 0;
  bit forceStall = 0;
  int img [16][W];
  int expS [4096], expM [4096];
  bit expE [4096], expB [4096];
  int wp = 0, rp = 0;

  always #5 clk = ~clk;

  wstream_win3 #(.PIX_W(PW), .IMG_W(W), .FILT(FILT_SUM)) u0 (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady0), .pixData(pixData),
    .pixSof(pixSof), .resValid(resValid0), .resReady(resReady), .resData(resData0),
    .resEol(resEol0));

  wstream_win3 #(.PIX_W(PW), .IMG_W(W), .FILT(FILT_MAX)) u1 (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady1), .pixData(pixData),
    .pixSof(pixSof), .resValid(resValid1), .resReady(resReady), .resData(resData1),
    .resEol(resEol1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic fillImg(input int seed, input int nRows);
    for (int r = 0; r < nRows; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = (r * (seed * 7 + 3) + c * (seed + 11) + seed * 29 + ((r * c) & 5)) & 255;
  endtask

  // expected result produced by accepting pixel (r,c), index n since sof
  task automatic pushExp(input int r, input int c, input int n);
    int cy, cx, s, m;
    if (n < 2 * W + 1) return;
    if (c >= 1) begin cy = r - 1; cx = c - 1; end
    else begin cy = r - 2; cx = W - 1; end
    s = 0; m = 0;
    if (cx != 0 && cx != W - 1) begin
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++) begin
          s += img[cy + dy][cx + dx];
          if (img[cy + dy][cx + dx] > m) m = img[cy + dy][cx + dx];
        end
    end
    expS[wp] = s; expM[wp] = m;
    expE[wp] = (cx == W - 1);
    expB[wp] = (cx == 0 || cx == W - 1);
    wp++;
  endtask

  // called at posedge+2; returns at posedge+2 after the accepting edge
  task automatic sendPix(input int r, input int c, input bit s, input int n);
    pixValid = 1; pixData = PW'(img[r][c]); pixSof = s;
    @(negedge clk);
    while (!pixReady0) @(negedge clk);
    pushExp(r, c, n);
    @(posedge clk); #2;
    pixValid = 0; pixSof = 0; pixData = 8'hA5;  // junk while idle (R7)
  endtask

  task automatic runFrame(input int seed, input int rows, input int tail, input int gap);
    int n;
    int lim;
    n = 0;
    fillImg(seed, rows + 1);
    for (int r = 0; r <= rows; r++) begin
      lim = (r == rows) ? tail : W;
      for (int c = 0; c < lim; c++) begin
        sendPix(r, c, n == 0, n);
        n++;
        if (gap != 0 && (n % gap) == 0) begin
          pixData = 8'h5A;
          @(posedge clk); #2;
        end
      end
    end
  endtask

  always @(posedge clk) cyc++;

  // output-ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      resReady = !forceStall && (stallCur == 0 || (cyc % stallCur) != 0);
    end
  end

  // result monitor
  bit prevStall = 0;
  logic [OW-1:0] heldData;
  bit heldEol;
  always @(negedge clk) begin
    if (!rst && resValid0) begin
      if (prevStall) begin
        chk("R6 data held under stall", int'(resData0), int'(heldData));
        chk("R6 eol held under stall", int'(resEol0), int'(heldEol));
      end
      if (!resReady) begin
        chk("R6 input stalled", int'(pixReady0), 0);
        prevStall = 1; heldData = resData0; heldEol = resEol0;
      end else begin
        prevStall = 0;
        if (rp >= wp) begin
          chk("R4 unexpected extra result", 1, 0);
        end else begin
          if (expB[rp]) chk("R3 border zero", int'(resData0), 0);
          else          chk("R2 window sum", int'(resData0), expS[rp]);
          chk("R9 window max", int'(resData1), expM[rp]);
          chk("R5 eol flag", int'(resEol0), int'(expE[rp]));
          rp++;
        end
      end
    end else begin
      prevStall = 0;
    end
  end

  initial begin
    while (cyc < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 resValid in reset", int'(resValid0), 0);
    chk("R1 pixReady in reset", int'(pixReady0), 1);
    @(posedge clk); #2; rst = 0;
    @(negedge clk);
    chk("R1 resValid after reset", int'(resValid0), 0);
    chk("R1 pixReady after reset", int'(pixReady0), 1);
    @(posedge clk); #2;

    // R4: first result exactly at pixel index 2W+1
    fillImg(9, 4);
    for (int n = 0; n <= 2 * W; n++) sendPix(n / W, n % W, n == 0, n);
    @(negedge clk);
    chk("R4 no result before 2W+2 pixels", int'(resValid0), 0);
    @(posedge clk); #2;
    forceStall = 1;
    sendPix(2, 1, 0, 2 * W + 1);
    @(negedge clk);
    chk("R4 first result valid", int'(resValid0), 1);
    chk("R3 first result is left border", int'(resData0), 0);
    chk("R5 first result no eol", int'(resEol0), 0);
    // R6: hold while new pixel waits
    fork
      begin
        sendPix(2, 2, 0, 2 * W + 2);
      end
      begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk("R6 stalled valid held", int'(resValid0), 1);
          chk("R6 stalled pixReady low", int'(pixReady0), 0);
        end
        forceStall = 0;
      end
    join
    for (int c = 3; c < W; c++) sendPix(2, c, 0, 2 * W + c);
    sendPix(3, 0, 0, 3 * W);
    repeat (4) @(negedge clk);
    chk("R4 all results delivered", rp, wp);

    // table of scenarios
    for (int s = 0; s < NSCN; s++) begin
      @(posedge clk); #2;
      stallCur = SCN[s][3];
      runFrame(SCN[s][4], SCN[s][0], SCN[s][1], SCN[s][2]);
      stallCur = 0;
      repeat (6) @(negedge clk);
      chk("R4 R8 results count per frame", rp, wp);
      chk("R7 no result without pixel", int'(resValid0), 0);
    end

    // R8: sof mid-row abandons partial row; sof pixel itself silent
    @(posedge clk); #2;
    fillImg(12, 3);
    for (int n = 0; n < W + 3; n++) sendPix(n / W, n % W, n == 0, n);
    runFrame(13, 4, 2, 0);
    repeat (6) @(negedge clk);
    chk("R8 restart result count", rp, wp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule